// File: doc/BRIEF.md
# Memory Error Capture and Interrupt Unit

This unit sits next to the ECC check logic of a memory data path. Every cycle the decoder may flag a correctable (single-bit) or uncorrectable (multi-bit) error together with the failing 64-bit data, the syndrome and the address. The unit keeps sticky per-type flags, snapshots the first reported error for the host and drives a level interrupt when an enabled flag is set. Single-bit errors are first accumulated in a counter, and only the Nth one raises the flag. Multi-bit errors raise their flag at once.

A small word-addressed register port lets the host read and write the unit. Writes take effect on the next clock edge and reads are combinational. The same port programs two data masks and an ECC mask. When injection is armed, these masks are XORed into the write data and check bits on their way to memory, which corrupts stored words for test. A configuration register turns error handling on and selects a 32-bit or 64-bit data bus. Both bits are also driven out to the data path.

Top module: `ecc_err_unit`

## Requirements
- R1: After reset every register reads 0, `irq` is low, and write data and check bits pass through unchanged.
- R2: The flag register (address 0) holds the single-bit flag in bit 0 and the multi-bit flag in bit 1. A 1 written to a bit clears that flag and a 0 leaves it. A flag raised in the same cycle as its clear stays set.
- R3: `irq` is high exactly while the flag register ANDed with the interrupt mask (address 1, bit 0 single, bit 1 multi) is nonzero. It updates in the cycle after a flag or mask changes.
- R4: The count limit sits in bits 23:16 of address 3, and all other bits of that register read 0. Each accepted single-bit error advances a counter. The error that brings the counter to the limit raises the single-bit flag and returns the counter to 0. A limit of 0 never raises the flag. Any write to address 3 zeroes the counter.
- R5: An accepted multi-bit error raises its flag in the next cycle, whatever the single-bit count is, and leaves that count untouched.
- R6: When an error raises a flag while both flags are clear, its data high word, data low word, syndrome and address appear at addresses 4, 5, 6 (bits 7:0) and 7 in the next cycle. While any flag is set, these capture registers keep their values. A single-bit error that does not reach the limit captures nothing.
- R7: Bit 0 (single) and bit 1 (multi) of the suppress register (address 2) make errors of that type be ignored: they do not count, raise a flag or capture. When bit 0 of the configuration register (address 11, ECC on) is clear, all errors are ignored.
- R8: Addresses 8 (high mask), 9 (low mask) and 10 (control) read back all 32 written bits. When bit 8 of address 10 is set, `wr_data_out` = `wr_data_in` XOR {high mask, low mask} and `wr_ecc_out` = `wr_ecc_in` XOR address 10 bits 7:0. When that bit is clear, both pass through unchanged.
- R9: Bit 1 of address 11 selects the 32-bit bus. In that mode the captured high word is stored as 0 and the high mask is not applied. `ecc_on` and `narrow_bus` show bits 0 and 1 of address 11.
- R10: Addresses 12 to 15 read 0, and writes to them or to the capture addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register word address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| err_valid | input | 1 | Decoder reports an error this cycle |
| err_single | input | 1 | Reported error is correctable |
| err_multi | input | 1 | Reported error is uncorrectable |
| err_data_hi | input | 32 | Failing data, upper word |
| err_data_lo | input | 32 | Failing data, lower word |
| err_syn | input | 8 | Syndrome of the failing word |
| err_addr | input | 32 | Address of the failing word |
| wr_data_in | input | 64 | Write data toward memory |
| wr_ecc_in | input | 8 | Check bits toward memory |
| wr_data_out | output | 64 | Write data after injection |
| wr_ecc_out | output | 8 | Check bits after injection |
| irq | output | 1 | Level interrupt |
| ecc_on | output | 1 | ECC handling enabled |
| narrow_bus | output | 1 | 32-bit bus selected |

## Verification
The hardest states to reach from the ports are the collisions: a host clear landing in the same cycle as a new error, a multi-bit error arriving while the single-bit counter is part-way to its limit, and a second error arriving while the capture is frozen. The stimulus reaches them with a single-cycle driver task that can present a register write and an error report in the same cycle. It first programs a limit of 3 and leaves the counter at 1 or 2 before sending the colliding event. A behavioural model in the bench tracks the counter as a plain integer, so a mismatch in the counter's phase shows up in the next read of the flag or capture registers.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
  localparam int ADDR_W      = 4;
  localparam int THR_LSB     = 16;
  localparam int INJ_ARM_BIT = 8;
  localparam int CFG_ON_BIT  = 0;
  localparam int CFG_NAR_BIT = 1;

  typedef enum logic [ADDR_W-1:0] {
    RA_FLAGS  = 4'd0,
    RA_IRQMSK = 4'd1,
    RA_SUPPR  = 4'd2,
    RA_LIMIT  = 4'd3,
    RA_CAPHI  = 4'd4,
    RA_CAPLO  = 4'd5,
    RA_CAPSYN = 4'd6,
    RA_CAPADR = 4'd7,
    RA_INJHI  = 4'd8,
    RA_INJLO  = 4'd9,
    RA_INJCTL = 4'd10,
    RA_CFG    = 4'd11
  } reg_sel_e;

  typedef struct packed {
    logic multi;
    logic single;
  } err_pair_t;
endpackage

// File: rtl/sbe_limit_counter.sv
module sbe_limit_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_nx;
  logic             armed;

  assign armed  = (limit != '0);
  assign cnt_nx = {1'b0, cnt_q} + 1'b1;
  assign hit    = inc && armed && (cnt_nx == {1'b0, limit});

  always_comb begin
    cnt_d = cnt_q;
    if (clr)               cnt_d = '0;
    else if (hit)          cnt_d = '0;
    else if (inc && armed) cnt_d = cnt_nx[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  cnt_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cnt_q < limit));
endmodule

// File: rtl/err_snapshot.sv
module err_snapshot #(
  parameter int WORD_W = 32,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              frozen,
  input  logic              narrow,
  input  logic [WORD_W-1:0] in_hi,
  input  logic [WORD_W-1:0] in_lo,
  input  logic [SYN_W-1:0]  in_syn,
  input  logic [WORD_W-1:0] in_addr,
  output logic [WORD_W-1:0] cap_hi,
  output logic [WORD_W-1:0] cap_lo,
  output logic [SYN_W-1:0]  cap_syn,
  output logic [WORD_W-1:0] cap_addr
);
  logic load;
  logic [WORD_W-1:0] hi_d;

  assign load = take && !frozen;
  assign hi_d = narrow ? '0 : in_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_hi   <= '0;
      cap_lo   <= '0;
      cap_syn  <= '0;
      cap_addr <= '0;
    end else if (load) begin
      cap_hi   <= hi_d;
      cap_lo   <= in_lo;
      cap_syn  <= in_syn;
      cap_addr <= in_addr;
    end
  end

  // R6
  cap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> ($stable(cap_lo) && $stable(cap_addr) && $stable(cap_syn) && $stable(cap_hi)));
endmodule

// File: rtl/wr_inject.sv
module wr_inject #(
  parameter int WORD_W = 32,
  parameter int SYN_W  = 8
) (
  input  logic [2*WORD_W-1:0] data_in,
  input  logic [SYN_W-1:0]    ecc_in,
  input  logic [WORD_W-1:0]   mask_hi,
  input  logic [WORD_W-1:0]   mask_lo,
  input  logic [SYN_W-1:0]    mask_ecc,
  input  logic                armed,
  input  logic                narrow,
  output logic [2*WORD_W-1:0] data_out,
  output logic [SYN_W-1:0]    ecc_out
);
  localparam int N_WORDS = 2;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] m;
    if (g == 0) begin : g_lo
      assign m = armed ? mask_lo : '0;
    end else begin : g_hi
      assign m = (armed && !narrow) ? mask_hi : '0;
    end
    assign data_out[g*WORD_W +: WORD_W] = data_in[g*WORD_W +: WORD_W] ^ m;
  end

  assign ecc_out = ecc_in ^ (armed ? mask_ecc : '0);
endmodule

// File: rtl/ecc_err_unit.sv
module ecc_err_unit
  import ecc_err_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SYN_W  = 8,
  parameter int LIM_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wen,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic                err_valid,
  input  logic                err_single,
  input  logic                err_multi,
  input  logic [WORD_W-1:0]   err_data_hi,
  input  logic [WORD_W-1:0]   err_data_lo,
  input  logic [SYN_W-1:0]    err_syn,
  input  logic [WORD_W-1:0]   err_addr,
  input  logic [2*WORD_W-1:0] wr_data_in,
  input  logic [SYN_W-1:0]    wr_ecc_in,
  output logic [2*WORD_W-1:0] wr_data_out,
  output logic [SYN_W-1:0]    wr_ecc_out,
  output logic                irq,
  output logic                ecc_on,
  output logic                narrow_bus
);
  localparam int PAD_W = WORD_W - 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  err_pair_t         flags_q, flags_d, irqm_q, irqm_d, supp_q, supp_d;
  logic [LIM_W-1:0]  lim_q, lim_d;
  logic [WORD_W-1:0] ihi_q, ihi_d, ilo_q, ilo_d, ictl_q, ictl_d;
  logic [1:0]        cfg_q, cfg_d;
  logic [WORD_W-1:0] cap_hi, cap_lo, cap_addr;
  logic [SYN_W-1:0]  cap_syn;
  logic              sbe_acc, mbe_acc, sbe_hit, lim_wr, frozen;
  reg_sel_e          sel;

  assign sel     = reg_sel_e'(reg_addr);
  assign sbe_acc = err_valid && err_single && cfg_q[CFG_ON_BIT] && !supp_q.single;
  assign mbe_acc = err_valid && err_multi  && cfg_q[CFG_ON_BIT] && !supp_q.multi;
  assign lim_wr  = reg_wen && (sel == RA_LIMIT);
  assign frozen  = flags_q.single || flags_q.multi;

  sbe_limit_counter #(.CNT_W(LIM_W)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .clr(lim_wr), .inc(sbe_acc),
    .limit(lim_q), .hit(sbe_hit)
  );

  err_snapshot #(.WORD_W(WORD_W), .SYN_W(SYN_W)) u_cap (
    .clk(clk), .rst_n(rst_i_n), .take(sbe_hit || mbe_acc), .frozen(frozen),
    .narrow(cfg_q[CFG_NAR_BIT]), .in_hi(err_data_hi), .in_lo(err_data_lo),
    .in_syn(err_syn), .in_addr(err_addr), .cap_hi(cap_hi), .cap_lo(cap_lo),
    .cap_syn(cap_syn), .cap_addr(cap_addr)
  );

  wr_inject #(.WORD_W(WORD_W), .SYN_W(SYN_W)) u_inj (
    .data_in(wr_data_in), .ecc_in(wr_ecc_in), .mask_hi(ihi_q), .mask_lo(ilo_q),
    .mask_ecc(ictl_q[SYN_W-1:0]), .armed(ictl_q[INJ_ARM_BIT]),
    .narrow(cfg_q[CFG_NAR_BIT]), .data_out(wr_data_out), .ecc_out(wr_ecc_out)
  );

  // next state of the host-visible registers
  always_comb begin
    flags_d = flags_q;
    irqm_d  = irqm_q;
    supp_d  = supp_q;
    lim_d   = lim_q;
    ihi_d   = ihi_q;
    ilo_d   = ilo_q;
    ictl_d  = ictl_q;
    cfg_d   = cfg_q;
    if (reg_wen) begin
      case (sel)
        RA_FLAGS:  flags_d = flags_q & ~err_pair_t'(reg_wdata[1:0]);
        RA_IRQMSK: irqm_d  = err_pair_t'(reg_wdata[1:0]);
        RA_SUPPR:  supp_d  = err_pair_t'(reg_wdata[1:0]);
        RA_LIMIT:  lim_d   = reg_wdata[THR_LSB +: LIM_W];
        RA_INJHI:  ihi_d   = reg_wdata;
        RA_INJLO:  ilo_d   = reg_wdata;
        RA_INJCTL: ictl_d  = reg_wdata;
        RA_CFG:    cfg_d   = reg_wdata[1:0];
        default: ;
      endcase
    end
    if (sbe_hit) flags_d.single = 1'b1;
    if (mbe_acc) flags_d.multi  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      flags_q <= '0;
      irqm_q  <= '0;
      supp_q  <= '0;
      lim_q   <= '0;
      ihi_q   <= '0;
      ilo_q   <= '0;
      ictl_q  <= '0;
      cfg_q   <= '0;
    end else begin
      flags_q <= flags_d;
      irqm_q  <= irqm_d;
      supp_q  <= supp_d;
      lim_q   <= lim_d;
      ihi_q   <= ihi_d;
      ilo_q   <= ilo_d;
      ictl_q  <= ictl_d;
      cfg_q   <= cfg_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      RA_FLAGS:  reg_rdata = {{PAD_W{1'b0}}, flags_q};
      RA_IRQMSK: reg_rdata = {{PAD_W{1'b0}}, irqm_q};
      RA_SUPPR:  reg_rdata = {{PAD_W{1'b0}}, supp_q};
      RA_LIMIT:  reg_rdata[THR_LSB +: LIM_W] = lim_q;
      RA_CAPHI:  reg_rdata = cap_hi;
      RA_CAPLO:  reg_rdata = cap_lo;
      RA_CAPSYN: reg_rdata[SYN_W-1:0] = cap_syn;
      RA_CAPADR: reg_rdata = cap_addr;
      RA_INJHI:  reg_rdata = ihi_q;
      RA_INJLO:  reg_rdata = ilo_q;
      RA_INJCTL: reg_rdata = ictl_q;
      RA_CFG:    reg_rdata = {{PAD_W{1'b0}}, cfg_q};
      default:   reg_rdata = '0;
    endcase
  end

  assign irq        = |(flags_q & irqm_q);
  assign ecc_on     = cfg_q[CFG_ON_BIT];
  assign narrow_bus = cfg_q[CFG_NAR_BIT];

  // R2
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (reg_wen && sel == RA_FLAGS && reg_wdata[0] && !sbe_hit) |=> !flags_q.single);
  // R4
  sbe_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(flags_q.single) |-> $past(sbe_hit));
  // R5
  mbe_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(flags_q.multi) |-> $past(mbe_acc));
  // R7
  suppressed_mbe_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((supp_q.multi || !cfg_q[CFG_ON_BIT]) && !flags_q.multi) |=> !flags_q.multi);
endmodule

// File: tb/ecc_err_unit_test.sv
`timescale 1ns/1ps
module ecc_err_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        err_valid = 1'b0, err_single = 1'b0, err_multi = 1'b0;
  logic [31:0] err_data_hi = '0, err_data_lo = '0, err_addr = '0;
  logic [7:0]  err_syn = '0;
  logic [63:0] wr_data_in = '0;
  logic [7:0]  wr_ecc_in = '0;
  logic [63:0] wr_data_out;
  logic [7:0]  wr_ecc_out;
  logic        irq, ecc_on, narrow_bus;

  int n_chk = 0, n_err = 0;
  bit run = 1'b0;
  logic [31:0] pat = 32'h1234_5678;

  // behavioural reference state
  logic [1:0]  m_det, m_ien, m_dis, m_cfg;
  int          m_thr, m_cnt;
  logic [31:0] m_chi, m_clo, m_cadr, m_ihi, m_ilo, m_ictl;
  logic [7:0]  m_csyn;

  always #2.5 clk = ~clk;

  ecc_err_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_valid(err_valid),
    .err_single(err_single), .err_multi(err_multi), .err_data_hi(err_data_hi),
    .err_data_lo(err_data_lo), .err_syn(err_syn), .err_addr(err_addr),
    .wr_data_in(wr_data_in), .wr_ecc_in(wr_ecc_in), .wr_data_out(wr_data_out),
    .wr_ecc_out(wr_ecc_out), .irq(irq), .ecc_on(ecc_on), .narrow_bus(narrow_bus)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a)
      4'd0:  return {30'b0, m_det};
      4'd1:  return {30'b0, m_ien};
      4'd2:  return {30'b0, m_dis};
      4'd3:  return 32'(m_thr) << 16;
      4'd4:  return m_chi;
      4'd5:  return m_clo;
      4'd6:  return {24'b0, m_csyn};
      4'd7:  return m_cadr;
      4'd8:  return m_ihi;
      4'd9:  return m_ilo;
      4'd10: return m_ictl;
      4'd11: return {30'b0, m_cfg};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_det = 0; m_ien = 0; m_dis = 0; m_cfg = 0; m_thr = 0; m_cnt = 0;
      m_chi = 0; m_clo = 0; m_cadr = 0; m_csyn = 0; m_ihi = 0; m_ilo = 0; m_ictl = 0;
    end else begin
      bit s_ok, m_ok, hit;
      s_ok = err_valid && err_single && m_cfg[0] && !m_dis[0];
      m_ok = err_valid && err_multi && m_cfg[0] && !m_dis[1];
      hit = 1'b0;
      if (s_ok && m_thr != 0) begin
        if (m_cnt + 1 == m_thr) begin hit = 1'b1; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end
      if ((hit || m_ok) && m_det == 2'b00) begin
        m_chi = m_cfg[1] ? 32'h0 : err_data_hi;
        m_clo = err_data_lo; m_csyn = err_syn; m_cadr = err_addr;
      end
      if (reg_wen) begin
        case (reg_addr)
          4'd0:  m_det = m_det & ~reg_wdata[1:0];
          4'd1:  m_ien = reg_wdata[1:0];
          4'd2:  m_dis = reg_wdata[1:0];
          4'd3:  begin m_thr = int'(reg_wdata[23:16]); m_cnt = 0; end
          4'd8:  m_ihi = reg_wdata;
          4'd9:  m_ilo = reg_wdata;
          4'd10: m_ictl = reg_wdata;
          4'd11: m_cfg = reg_wdata[1:0];
          default: ;
        endcase
      end
      if (hit)  m_det[0] = 1'b1;
      if (m_ok) m_det[1] = 1'b1;
    end
  end

  // per-cycle comparison against the reference
  always @(posedge clk) begin
    if (run) begin
      logic [31:0] mh, ml;
      #1;
      mh = (m_ictl[8] && !m_cfg[1]) ? m_ihi : 32'h0;
      ml = m_ictl[8] ? m_ilo : 32'h0;
      check("R3 irq", {63'b0, irq}, {63'b0, |(m_det & m_ien)});
      check("R8 data", wr_data_out, wr_data_in ^ {mh, ml});
      check("R8 ecc", {56'b0, wr_ecc_out}, {56'b0, wr_ecc_in ^ (m_ictl[8] ? m_ictl[7:0] : 8'h0)});
      check("R9 cfg pins", {62'b0, narrow_bus, ecc_on}, {62'b0, m_cfg});
    end
  end

  task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d,
                      input logic s, input logic m, input logic [31:0] h,
                      input logic [31:0] l, input logic [7:0] y, input logic [31:0] ea);
    @(negedge clk);
    reg_wen = w; reg_addr = a; reg_wdata = d;
    err_valid = s | m; err_single = s; err_multi = m;
    err_data_hi = h; err_data_lo = l; err_syn = y; err_addr = ea;
    pat = pat * 32'h0019_660D + 32'h3C6E_F35F;
    wr_data_in = {pat, ~pat ^ 32'h5A5A_A5A5};
    wr_ecc_in = pat[15:8];
    @(negedge clk);
    reg_wen = 1'b0; err_valid = 1'b0; err_single = 1'b0; err_multi = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 0, 0, 0, 0);
  endtask

  task automatic sbe(input logic [31:0] h, input logic [31:0] l, input logic [7:0] y, input logic [31:0] ea);
    step(1'b0, 4'd0, 0, 1'b1, 1'b0, h, l, y, ea);
  endtask

  task automatic mbe(input logic [31:0] h, input logic [31:0] l, input logic [7:0] y, input logic [31:0] ea);
    step(1'b0, 4'd0, 0, 1'b0, 1'b1, h, l, y, ea);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, {32'b0, reg_rdata}, {32'b0, model_read(a)});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    run = 1'b1;

    // R1 reset values
    for (int a = 0; a < 16; a++) rd(4'(a), "R1 reset read");
    check("R1 irq low", {63'b0, irq}, 64'h0);

    // R8 injection registers and masking
    wr(4'd8, 32'hDEAD_BEEF); wr(4'd9, 32'h0F0F_1234); wr(4'd10, 32'hA5A5_01C3);
    rd(4'd8, "R8 hi mask"); rd(4'd9, "R8 lo mask"); rd(4'd10, "R8 ctl");
    repeat (4) step(1'b0, 4'd0, 0, 1'b0, 1'b0, 0, 0, 0, 0);
    wr(4'd10, 32'h0000_00FF);
    repeat (3) step(1'b0, 4'd0, 0, 1'b0, 1'b0, 0, 0, 0, 0);

    // R10 unmapped and read-only addresses
    wr(4'd12, 32'hFFFF_FFFF); wr(4'd4, 32'h1111_1111);
    rd(4'd12, "R10 unmapped"); rd(4'd15, "R10 unmapped"); rd(4'd4, "R10 capture ro");

    // R7 ECC off: errors ignored
    wr(4'd1, 32'h3); wr(4'd3, 32'h0001_0000);
    mbe(32'h1, 32'h2, 8'h3, 32'h4);
    rd(4'd0, "R7 ecc off flags"); rd(4'd7, "R7 ecc off capture");

    // R4 limit 3: two errors pending, third raises the flag
    wr(4'd11, 32'h1); wr(4'd3, 32'hFF03_FFFF);
    rd(4'd3, "R4 limit field");
    sbe(32'hAAAA_0001, 32'hBBBB_0001, 8'h11, 32'h0000_1000);
    sbe(32'hAAAA_0002, 32'hBBBB_0002, 8'h12, 32'h0000_2000);
    rd(4'd0, "R4 below limit"); rd(4'd5, "R6 no capture below limit");
    sbe(32'hAAAA_0003, 32'hBBBB_0003, 8'h13, 32'h0000_3000);
    rd(4'd0, "R4 limit reached");
    check("R3 irq on sbe", {63'b0, irq}, 64'h1);
    rd(4'd4, "R6 cap hi"); rd(4'd5, "R6 cap lo"); rd(4'd6, "R6 cap syn"); rd(4'd7, "R6 cap addr");

    // R6 frozen while flagged; R5 multi flag still rises
    mbe(32'hCCCC_0000, 32'hDDDD_0000, 8'h77, 32'h0000_9000);
    rd(4'd0, "R5 mbe flag"); rd(4'd4, "R6 frozen hi"); rd(4'd7, "R6 frozen addr");

    // R2 W1C per bit then all ones
    wr(4'd0, 32'h1);
    rd(4'd0, "R2 clear single only");
    wr(4'd1, 32'h1);
    check("R3 irq masked", {63'b0, irq}, 64'h0);
    wr(4'd1, 32'h3);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, "R2 clear all");

    // R5 multi during a partial count, counter untouched
    sbe(32'h1, 32'h2, 8'h01, 32'h10);
    mbe(32'hEEEE_0001, 32'hFFFF_0001, 8'h55, 32'h0000_A000);
    rd(4'd0, "R5 immediate"); rd(4'd5, "R5 mbe capture lo");
    wr(4'd0, 32'h3);
    sbe(32'h3, 32'h4, 8'h02, 32'h20);
    rd(4'd0, "R5 count kept");
    sbe(32'h5, 32'h6, 8'h03, 32'h30);
    rd(4'd0, "R5 count completes"); rd(4'd7, "R6 addr after count");
    wr(4'd0, 32'h3);

    // R4 write to limit zeroes the counter
    sbe(32'h7, 32'h8, 8'h04, 32'h40); sbe(32'h7, 32'h8, 8'h04, 32'h40);
    wr(4'd3, 32'h0003_0000);
    sbe(32'h9, 32'hA, 8'h05, 32'h50);
    rd(4'd0, "R4 counter cleared by write");
    sbe(32'h9, 32'hA, 8'h05, 32'h50); sbe(32'h9, 32'hA, 8'h05, 32'h50);
    rd(4'd0, "R4 flag after fresh count");
    wr(4'd0, 32'h3);

    // R2 set wins over clear in the same cycle
    wr(4'd3, 32'h0001_0000);
    step(1'b1, 4'd0, 32'h1, 1'b1, 1'b0, 32'h1, 32'h1, 8'h1, 32'h1);
    rd(4'd0, "R2 set wins");
    wr(4'd0, 32'h3);

    // R4 limit zero never flags
    wr(4'd3, 32'h0);
    repeat (5) sbe(32'h2, 32'h2, 8'h2, 32'h2);
    rd(4'd0, "R4 limit zero");

    // R7 per-type suppression
    wr(4'd3, 32'h0001_0000); wr(4'd2, 32'h3);
    sbe(32'h3, 32'h3, 8'h3, 32'h3); mbe(32'h3, 32'h3, 8'h3, 32'h3);
    rd(4'd0, "R7 suppressed"); rd(4'd2, "R7 suppress reg");
    wr(4'd2, 32'h1);
    mbe(32'h4444_0000, 32'h5555_0000, 8'h66, 32'hB000);
    rd(4'd0, "R7 multi still accepted");
    wr(4'd0, 32'h3); wr(4'd2, 32'h0);

    // R9 narrow bus
    wr(4'd11, 32'h3); wr(4'd8, 32'hFFFF_0000); wr(4'd10, 32'h0000_0100);
    repeat (3) step(1'b0, 4'd0, 0, 1'b0, 1'b0, 0, 0, 0, 0);
    mbe(32'h9999_9999, 32'h8888_8888, 8'h99, 32'hC000);
    rd(4'd4, "R9 narrow hi zero"); rd(4'd5, "R9 narrow lo"); rd(4'd11, "R9 cfg");
    wr(4'd0, 32'h3);

    repeat (2) @(posedge clk);
    run = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule